// File: doc/BRIEF.md
# Target-Keyed Branch Target Instruction Cache

This block remembers the first few instructions that were fetched at the destination of a change of flow. It keeps a small set of fully associative lines. Each line is tagged with the full byte address of a branch target and holds up to `WORDS` consecutive instructions found there. When the front end signals a change of flow, the target address is compared against every valid line. On a hit, the stored instructions are played back one per cycle. The fetch unit can use them while the slower memory request is still in flight.

On a miss, the block claims a line in first-in first-out order and fills it from the instruction responses that follow. Each response is first captured into a staging register and is written into the line one cycle later. A line becomes usable only when it closes. It closes either when it is full or when the next change of flow arrives with at least two instructions stored. With exactly one instruction stored, the line is discarded. With none stored, the same line is handed to the new target. A per-cycle inhibit input keeps selected code regions out of the cache, and a flush input empties the cache in one cycle.

Top module: `tic_cache`

## Requirements
- R1: After reset, no line is valid and `hit`, `miss` and `stream_valid` are 0. The first change of flow reports a miss.
- R2: `cof_valid` sampled high (with `flush` low) makes exactly one of `hit` or `miss` high for the single following cycle. A hit requires a valid line whose key equals the full `cof_addr`, with `inhibit` low.
- R3: On a hit, `stream_valid` is high from the cycle after the change of flow for n consecutive cycles, where n is the line's stored count. `stream_insn` carries the stored instructions in fetch order, and `stream_last` marks the final one.
- R4: After a miss that opens a line, each `ftch_valid` response is written into the next entry one cycle after it is sampled. The line closes as valid once `WORDS` entries are written. A response sampled in the same cycle as a change of flow, or while no line is open, is not stored.
- R5: A change of flow that finds the open line holding two or more instructions closes that line as valid, with that count.
- R6: A change of flow that finds the open line holding exactly one instruction leaves that line invalid.
- R7: A change of flow that finds the open line holding no instruction gives that same line to the new target. The FIFO position does not advance.
- R8: Lines are allocated in first-in first-out order, wrapping over `LINES` lines. Hits do not change this order.
- R9: A change of flow with `inhibit` high reports a miss and opens no line, so later responses are not cached.
- R10: A hit opens no line. Responses fetched after a hit leave the hit line's contents and count unchanged.
- R11: A valid line always holds between 2 and `WORDS` instructions, and no two valid lines share a key. A change of flow to the key of the open line, when that line holds two or more instructions, closes it and opens nothing.
- R12: `flush` high for one cycle ends any playback and invalidates all lines. Every later change of flow misses until it is refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate every line and stop playback |
| inhibit | input | 1 | Current fetch is in a region that must not be cached |
| cof_valid | input | 1 | Change-of-flow strobe |
| cof_addr | input | ADDR_W | Branch target address used as the lookup key |
| ftch_valid | input | 1 | Instruction response strobe from the fetch path |
| ftch_insn | input | INSN_W | Instruction carried by the response |
| hit | output | 1 | Lookup hit, one cycle after the change of flow |
| miss | output | 1 | Lookup miss, one cycle after the change of flow |
| stream_valid | output | 1 | A cached instruction is being delivered |
| stream_insn | output | INSN_W | Delivered cached instruction |
| stream_last | output | 1 | Final instruction of the line |

## Verification
Some rules hold on every cycle, and the assertions check those: one hit or miss per change of flow, a hit coinciding with the first playback beat, playback ending after its last beat, every valid line holding at least two instructions, lookup matching at most one line, and a flush leaving nothing valid. The close, invalidate and reuse decisions can only be seen through later lookups, and so can FIFO eviction order, the effect of inhibit, and the fact that responses after a hit are ignored. The bench shows these with sequences of changes of flow, checking which targets later hit and with what stored count and data.

// File: rtl/tic_pkg.sv
package tic_pkg;
   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_OPEN = 1'b1
   } fill_st_e;

   function automatic int cnt_bits(input int words);
      return $clog2(words + 1);
   endfunction
endpackage

// File: rtl/tic_lookup.sv
module tic_lookup #(
   parameter int LINES = 8,
   parameter int KEY_W = 32,
   localparam int LW = $clog2(LINES)
) (
   input  logic [LINES-1:0][KEY_W-1:0] keys,
   input  logic [LINES-1:0]            valid,
   input  logic [KEY_W-1:0]            key,
   output logic [LINES-1:0]            match_vec,
   output logic                        any_match,
   output logic [LW-1:0]               match_idx
);
   for (genvar g = 0; g < LINES; g++) begin : g_cmp
      assign match_vec[g] = valid[g] && (keys[g] == key);
   end

   assign any_match = |match_vec;

   always_comb begin
      match_idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (match_vec[i]) match_idx = LW'(i);
      end
   end
endmodule

// File: rtl/tic_fill.sv
module tic_fill import tic_pkg::*; #(
   parameter int LINES  = 8,
   parameter int WORDS  = 4,
   parameter int INSN_W = 32,
   parameter int KEY_W  = 32,
   localparam int LW = $clog2(LINES),
   localparam int SW = $clog2(WORDS),
   localparam int CW = cnt_bits(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              cof,
   input  logic [KEY_W-1:0]  cof_key,
   input  logic              hit,
   input  logic              inhibit,
   input  logic              ftch_valid,
   input  logic [INSN_W-1:0] ftch_data,
   output logic              wr_en,
   output logic [LW-1:0]     wr_line,
   output logic [SW-1:0]     wr_slot,
   output logic [INSN_W-1:0] wr_data,
   output logic              open_en,
   output logic [LW-1:0]     open_line,
   output logic              close_en,
   output logic              close_ok,
   output logic [LW-1:0]     close_line,
   output logic [CW-1:0]     close_cnt
);
   fill_st_e            st_q;
   logic [LW-1:0]       line_q;
   logic [KEY_W-1:0]    key_q;
   logic [CW-1:0]       cnt_q;
   logic                stg_v_q;
   logic [INSN_W-1:0]   stg_d_q;
   logic [LW-1:0]       fifo_q;

   logic          is_open;
   logic          cof_act;
   logic [CW-1:0] eff;
   logic          dup;
   logic          reuse;
   logic          full_now;
   logic          capture;

   always_comb begin
      is_open  = (st_q == FS_OPEN);
      cof_act  = cof && !flush;
      eff      = cnt_q + CW'(stg_v_q);
      dup      = is_open && (eff >= CW'(2)) && (cof_key == key_q);
      reuse    = is_open && (eff == '0);
      wr_en    = is_open && stg_v_q && !flush;
      wr_line  = line_q;
      wr_slot  = cnt_q[SW-1:0];
      wr_data  = stg_d_q;
      full_now = wr_en && (cnt_q + CW'(1) == CW'(WORDS));
      open_en  = cof_act && !inhibit && !hit && !dup;
      open_line = reuse ? line_q : fifo_q;
      close_line = line_q;
      close_cnt  = eff;
      if (cof_act) begin
         close_en = is_open && (eff != '0);
         close_ok = (eff >= CW'(2));
      end else begin
         close_en = full_now;
         close_ok = 1'b1;
      end
      capture = is_open && ftch_valid && (eff < CW'(WORDS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= FS_IDLE;
         line_q  <= '0;
         key_q   <= '0;
         cnt_q   <= '0;
         stg_v_q <= 1'b0;
         stg_d_q <= '0;
         fifo_q  <= '0;
      end else if (flush) begin
         st_q    <= FS_IDLE;
         cnt_q   <= '0;
         stg_v_q <= 1'b0;
         fifo_q  <= '0;
      end else if (cof_act) begin
         st_q    <= open_en ? FS_OPEN : FS_IDLE;
         line_q  <= open_line;
         key_q   <= cof_key;
         cnt_q   <= '0;
         stg_v_q <= 1'b0;
         if (open_en && !reuse) fifo_q <= fifo_q + LW'(1);
      end else begin
         if (wr_en) cnt_q <= cnt_q + CW'(1);
         if (full_now) st_q <= FS_IDLE;
         stg_v_q <= capture;
         if (capture) stg_d_q <= ftch_data;
      end
   end
endmodule

// File: rtl/tic_stream.sv
module tic_stream import tic_pkg::*; #(
   parameter int LINES = 8,
   parameter int WORDS = 4,
   localparam int LW = $clog2(LINES),
   localparam int SW = $clog2(WORDS),
   localparam int CW = cnt_bits(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          cof,
   input  logic          hit,
   input  logic [LW-1:0] hit_line,
   input  logic [CW-1:0] hit_len,
   output logic          hit_o,
   output logic          miss_o,
   output logic          act_o,
   output logic [LW-1:0] line_o,
   output logic [SW-1:0] ptr_o,
   output logic          last_o
);
   logic [CW-1:0] len_q;

   assign last_o = act_o && ((CW'(ptr_o) + CW'(1)) == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o  <= 1'b0;
         miss_o <= 1'b0;
         act_o  <= 1'b0;
         line_o <= '0;
         ptr_o  <= '0;
         len_q  <= '0;
      end else if (flush) begin
         hit_o  <= 1'b0;
         miss_o <= 1'b0;
         act_o  <= 1'b0;
         ptr_o  <= '0;
      end else if (cof) begin
         hit_o  <= hit;
         miss_o <= !hit;
         act_o  <= hit;
         line_o <= hit_line;
         ptr_o  <= '0;
         len_q  <= hit_len;
      end else begin
         hit_o  <= 1'b0;
         miss_o <= 1'b0;
         if (act_o) begin
            if (last_o) act_o <= 1'b0;
            else        ptr_o <= ptr_o + SW'(1);
         end
      end
   end
endmodule

// File: rtl/tic_cache.sv
module tic_cache import tic_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int INSN_W = 32,
   parameter int LINES  = 8,
   parameter int WORDS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              inhibit,
   input  logic              cof_valid,
   input  logic [ADDR_W-1:0] cof_addr,
   input  logic              ftch_valid,
   input  logic [INSN_W-1:0] ftch_insn,
   output logic              hit,
   output logic              miss,
   output logic              stream_valid,
   output logic [INSN_W-1:0] stream_insn,
   output logic              stream_last
);
   localparam int LW = $clog2(LINES);
   localparam int SW = $clog2(WORDS);
   localparam int CW = cnt_bits(WORDS);

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two and at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two and at least 2");
   end

   logic [LINES-1:0]              line_valid_q;
   logic [LINES-1:0][ADDR_W-1:0]  line_key_q;
   logic [LINES-1:0][CW-1:0]      line_cnt_q;
   logic [INSN_W-1:0]             mem_q [LINES][WORDS];

   logic [LINES-1:0] match_vec;
   logic             any_match;
   logic [LW-1:0]    match_idx;
   logic             hit_eff;

   logic              wr_en;
   logic [LW-1:0]     wr_line;
   logic [SW-1:0]     wr_slot;
   logic [INSN_W-1:0] wr_data;
   logic              open_en;
   logic [LW-1:0]     open_line;
   logic              close_en;
   logic              close_ok;
   logic [LW-1:0]     close_line;
   logic [CW-1:0]     close_cnt;

   logic          cof_act;
   logic [LW-1:0] str_line;
   logic [SW-1:0] str_ptr;

   assign cof_act = cof_valid && !flush;
   assign hit_eff = any_match && !inhibit;

   tic_lookup #(.LINES(LINES), .KEY_W(ADDR_W)) u_lookup (
      .keys      (line_key_q),
      .valid     (line_valid_q),
      .key       (cof_addr),
      .match_vec (match_vec),
      .any_match (any_match),
      .match_idx (match_idx)
   );

   tic_fill #(.LINES(LINES), .WORDS(WORDS), .INSN_W(INSN_W), .KEY_W(ADDR_W)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .cof        (cof_valid),
      .cof_key    (cof_addr),
      .hit        (hit_eff),
      .inhibit    (inhibit),
      .ftch_valid (ftch_valid),
      .ftch_data  (ftch_insn),
      .wr_en      (wr_en),
      .wr_line    (wr_line),
      .wr_slot    (wr_slot),
      .wr_data    (wr_data),
      .open_en    (open_en),
      .open_line  (open_line),
      .close_en   (close_en),
      .close_ok   (close_ok),
      .close_line (close_line),
      .close_cnt  (close_cnt)
   );

   tic_stream #(.LINES(LINES), .WORDS(WORDS)) u_stream (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .cof      (cof_act),
      .hit      (hit_eff),
      .hit_line (match_idx),
      .hit_len  (line_cnt_q[match_idx]),
      .hit_o    (hit),
      .miss_o   (miss),
      .act_o    (stream_valid),
      .line_o   (str_line),
      .ptr_o    (str_ptr),
      .last_o   (stream_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_valid_q <= '0;
         line_key_q   <= '0;
         line_cnt_q   <= '0;
      end else if (flush) begin
         line_valid_q <= '0;
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (close_en && close_line == LW'(i)) begin
               line_valid_q[i] <= close_ok;
               line_cnt_q[i]   <= close_cnt;
            end
            if (open_en && open_line == LW'(i)) begin
               line_valid_q[i] <= 1'b0;
               line_key_q[i]   <= cof_addr;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_line][wr_slot] <= wr_data;
   end

   assign stream_insn = stream_valid ? mem_q[str_line][str_ptr] : '0;
endmodule

// File: rtl/tic_cache_chk.sv
module tic_cache_chk #(
   parameter int LINES = 8,
   parameter int CW    = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     flush,
   input logic                     cof_valid,
   input logic                     hit,
   input logic                     miss,
   input logic                     stream_valid,
   input logic                     stream_last,
   input logic [LINES-1:0]         line_valid_q,
   input logic [LINES-1:0][CW-1:0] line_cnt_q,
   input logic [LINES-1:0]         match_vec
);
   assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cof_valid && !flush) |=> (hit ^ miss));

   assert_no_spurious_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cof_valid && !flush) |=> !(hit || miss));

   assert_hit_starts_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> stream_valid);

   assert_stream_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_valid && stream_last && !cof_valid) |=> !stream_valid);

   assert_unique_key_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   assert_flush_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (line_valid_q == '0) && !stream_valid && !hit);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      assert_line_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
         line_valid_q[g] |-> (line_cnt_q[g] >= CW'(2)));
   end
endmodule

bind tic_cache tic_cache_chk #(.LINES(LINES), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .cof_valid    (cof_valid),
   .hit          (hit),
   .miss         (miss),
   .stream_valid (stream_valid),
   .stream_last  (stream_last),
   .line_valid_q (line_valid_q),
   .line_cnt_q   (line_cnt_q),
   .match_vec    (match_vec)
);

// File: tb/sim_tic_cache.sv
module sim_tic_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        inhibit = 1'b0;
   logic        cof_valid = 1'b0;
   logic [31:0] cof_addr = '0;
   logic        ftch_valid = 1'b0;
   logic [31:0] ftch_insn = '0;
   logic        hit, miss, stream_valid, stream_last;
   logic [31:0] stream_insn;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tic_cache u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .inhibit(inhibit),
      .cof_valid(cof_valid), .cof_addr(cof_addr),
      .ftch_valid(ftch_valid), .ftch_insn(ftch_insn),
      .hit(hit), .miss(miss), .stream_valid(stream_valid),
      .stream_insn(stream_insn), .stream_last(stream_last)
   );

   // Vector fields: [31:16] target, [15:12] fetches, [11:8] expected length,
   // [7] expect hit, [6] inhibit, [3:0] requirement number.
   function automatic logic [31:0] mkv(input logic [15:0] t, input int nf, input int len,
                                       input bit h, input bit inh, input int req);
      return {t, 4'(nf), 4'(len), h, inh, 2'b00, 4'(req)};
   endfunction

   function automatic string rtag(input int n);
      case (n)
         1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
         5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
         9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
         default: return "R?";
      endcase
   endfunction

   function automatic logic [31:0] insn(input logic [15:0] t, input int i);
      return {t, 8'hA5, 8'(i)};
   endfunction

   localparam int NV = 28;
   localparam logic [31:0] VECS [NV] = '{
      mkv(16'h0100, 4, 0, 0, 0, 4),  // R4 fill A to full
      mkv(16'h0100, 0, 4, 1, 0, 3),  // R3 replay A
      mkv(16'h0200, 2, 0, 0, 0, 4),  // B gets two entries
      mkv(16'h0300, 1, 0, 0, 0, 5),  // R5 closes B, C gets one
      mkv(16'h0400, 0, 0, 0, 0, 6),  // R6 drops C, D opens empty
      mkv(16'h0500, 3, 0, 0, 0, 7),  // R7 E takes D's line
      mkv(16'h0200, 0, 2, 1, 0, 5),  // R5 B holds two
      mkv(16'h0500, 0, 3, 1, 0, 7),  // R7 E holds three
      mkv(16'h0300, 0, 0, 0, 0, 6),  // R6 C was dropped
      mkv(16'h0400, 4, 0, 0, 0, 7),  // R7 D reuses C's empty line
      mkv(16'h0400, 0, 4, 1, 0, 7),
      mkv(16'h0100, 0, 4, 1, 0, 8),  // R8 hit on oldest line
      mkv(16'h0600, 4, 0, 0, 0, 8),
      mkv(16'h0700, 4, 0, 0, 0, 8),
      mkv(16'h0800, 4, 0, 0, 0, 8),
      mkv(16'h0900, 4, 0, 0, 0, 8),  // R8 wraps onto A's line
      mkv(16'h0100, 2, 0, 0, 0, 8),  // R8 A evicted despite hit
      mkv(16'h0200, 0, 0, 0, 0, 8),  // R8 B evicted next
      mkv(16'h0900, 0, 4, 1, 0, 8),
      mkv(16'h0100, 0, 2, 1, 0, 5),
      mkv(16'h0500, 0, 3, 1, 0, 8),
      mkv(16'h0100, 2, 2, 1, 0, 10), // R10 responses after hit
      mkv(16'h0100, 0, 2, 1, 0, 10), // R10 line unchanged
      mkv(16'h0A00, 4, 0, 0, 1, 9),  // R9 inhibited
      mkv(16'h0A00, 0, 0, 0, 0, 9),  // R9 nothing cached
      mkv(16'h0B00, 2, 0, 0, 0, 11),
      mkv(16'h0B00, 0, 0, 0, 0, 11), // R11 same key closes, no new line
      mkv(16'h0B00, 0, 2, 1, 0, 11)
   };

   task automatic check(input bit ok, input int req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", rtag(req), what, act, exp);
      end
   endtask

   task automatic run_vec(input logic [31:0] v);
      logic [15:0] t;
      int nf, len, req;
      bit eh;
      t = v[31:16]; nf = int'(v[15:12]); len = int'(v[11:8]);
      eh = v[7]; req = int'(v[3:0]);
      cof_valid = 1'b1; cof_addr = {16'h0, t}; inhibit = v[6];
      @(posedge clk); @(negedge clk);
      cof_valid = 1'b0;
      check(hit == eh && miss == !eh, 2, $sformatf("lookup %h hit/miss", t),
            {30'b0, hit, miss}, {30'b0, eh, !eh});
      if (eh) begin
         for (int i = 0; i < len; i++) begin
            check(stream_valid && stream_insn == insn(t, i) && stream_last == (i == len - 1),
                  req, $sformatf("beat %0d of %h", i, t), stream_insn, insn(t, i));
            @(negedge clk);
         end
         check(!stream_valid, 3, "stream stops after count", {31'b0, stream_valid}, 32'h0);
      end
      for (int i = 0; i < nf; i++) begin
         ftch_valid = 1'b1; ftch_insn = insn(t, i);
         @(negedge clk);
      end
      ftch_valid = 1'b0; inhibit = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!hit && !miss && !stream_valid, 1, "reset outputs",
            {29'b0, hit, miss, stream_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!hit && !miss && !stream_valid, 1, "idle after reset",
            {29'b0, hit, miss, stream_valid}, 32'h0);

      for (int k = 0; k < NV; k++) run_vec(VECS[k]);

      // R12: flush in the middle of a replay
      cof_valid = 1'b1; cof_addr = 32'h0100;
      @(posedge clk); @(negedge clk);
      cof_valid = 1'b0;
      check(hit && stream_valid, 12, "hit before flush", {30'b0, hit, stream_valid}, 32'h3);
      flush = 1'b1;
      @(posedge clk); @(negedge clk);
      flush = 1'b0;
      check(!stream_valid && !hit, 12, "replay stopped by flush",
            {30'b0, hit, stream_valid}, 32'h0);
      run_vec(mkv(16'h0100, 0, 0, 0, 0, 12));
      run_vec(mkv(16'h0900, 0, 0, 0, 0, 12));
      run_vec(mkv(16'h0B00, 0, 0, 0, 0, 12));

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule